// File: doc/BRIEF.md
# Shared-Clock Serial Converter Control Sequencer

This block is the digital control front end of a serial multichannel converter that has only one clock input. That clock does two jobs. It shifts in the channel address while select is low. It paces the conversion once select has gone high. The analog sample-and-hold, the comparator and the approximation data path are outside this block. Here the conversion is shown only as an enable window of fixed length.

When select falls, the block spends two clocks recognising the low level, and these clocks shift in nothing. The clocks that follow are the valid I/O cycles:

- The first four valid cycles load a 4-bit channel address, MSB first.
- The falling edge of the fourth valid cycle marks the start of sampling.
- The falling edge of the tenth valid cycle marks the hold instant.

Select must rise after exactly twelve clocks. That rise opens the conversion window. Clocks beyond twelve with select still low are flagged as a framing error.

The address arrives as a plain serial bit with no back-pressure, and all pins are plain control and status pins. There is no valid/ready stream here, because the source shifts the address on the clock whether or not it is accepted.

Top module: `adc_shared_clk_seq`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted, the outputs `chan`, `chan_bad`, `sample_pulse`, `hold_pulse`, `conv_en` and `frame_err` are cleared, and the block waits for `cs_n` to be seen low.
- R2: The two rising clock edges at which `cs_n` is first sampled low are recognition cycles, and the `addr_in` values sampled at those edges never reach `chan`.
- R3: `addr_in` is sampled on rising edges 3 to 6 of the frame, MSB first, and `chan` holds the resulting 4-bit value from the cycle after edge 6 until the next frame loads a new one.
- R4: `chan_bad` is 1 exactly when the latched `chan` is greater than 10.
- R5: `sample_pulse` rises on the falling edge after frame rising edge 6 (valid cycle 4) and lasts exactly one clock.
- R6: `hold_pulse` rises on the falling edge after frame rising edge 12 (valid cycle 10), lasts one clock, and does not repeat if `cs_n` stays low.
- R7: `frame_err` is set when `cs_n` is still low at frame rising edge 13 or later, and is cleared at the first edge of the next frame.
- R8: `cs_n` sampled high at the rising edge after edge 12 makes `conv_en` high for exactly `CONV_CYCLES` clocks (default 44), starting at that edge.
- R9: `cs_n` going low during the conversion window starts no frame and no strobe, and leaves `chan` unchanged.
- R10: `cs_n` rising before frame edge 12 ends the frame with no hold pulse and no conversion window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, used for I/O shifting and for conversion |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| addr_in | input | 1 | Serial channel address, MSB first |
| chan | output | 4 | Latched channel address |
| chan_bad | output | 1 | Latched address selects no input (above 10) |
| sample_pulse | output | 1 | One-clock strobe at the start of sampling |
| hold_pulse | output | 1 | One-clock strobe at the hold instant |
| conv_en | output | 1 | Conversion window active |
| frame_err | output | 1 | Select held low past the twelfth clock |

## Verification
All sixteen address codes go through correctly framed transfers, with ones driven during the recognition clocks. A wrong result there separates a shifter that starts too early from one with the wrong bit order or the wrong range check.

Further frames hold select low past the twelfth clock, or raise it early after eight clocks. These separate a counter that stops at twelve from one that wraps or re-fires the hold strobe. They also show whether an aborted frame still opens a conversion window.

A select pulse placed inside the conversion window shows whether the window really masks select. The length of every window is counted against `CONV_CYCLES`.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FRAME = 2'd1,
    PH_CONV  = 2'd2
  } phase_e;
endpackage

// File: rtl/adcseq_frame_ctl.sv
module adcseq_frame_ctl
  import adcseq_pkg::*;
#(
  parameter int TOTAL       = 12,
  parameter int CONV_CYCLES = 44,
  localparam int CW = $clog2(TOTAL + 1),
  localparam int KW = $clog2(CONV_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  output phase_e        phase,
  output logic [CW-1:0] rcnt,
  output logic          frame_err,
  output logic          conv_en
);
  logic [KW-1:0] ccnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      rcnt      <= '0;
      frame_err <= 1'b0;
      ccnt      <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (!cs_n) begin
            phase     <= PH_FRAME;
            rcnt      <= CW'(1);
            frame_err <= 1'b0;
          end
        end
        PH_FRAME: begin
          if (cs_n) begin
            rcnt <= '0;
            if (rcnt == CW'(TOTAL)) begin
              phase <= PH_CONV;
              ccnt  <= KW'(CONV_CYCLES - 1);
            end else begin
              phase <= PH_IDLE;
            end
          end else if (rcnt < CW'(TOTAL)) begin
            rcnt <= rcnt + CW'(1);
          end else begin
            frame_err <= 1'b1;
          end
        end
        PH_CONV: begin
          if (ccnt == '0) phase <= PH_IDLE;
          else            ccnt  <= ccnt - KW'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign conv_en = (phase == PH_CONV);
endmodule

// File: rtl/adcseq_addr_shift.sv
module adcseq_addr_shift #(
  parameter int ADDR_W   = 4,
  parameter int MAX_CHAN = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              load_en,
  input  logic              addr_in,
  output logic [ADDR_W-1:0] chan,
  output logic              chan_bad
);
  logic [ADDR_W-1:0] sh;
  logic [ADDR_W-1:0] nxt;

  assign nxt = {sh[ADDR_W-2:0], addr_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      chan     <= '0;
      chan_bad <= 1'b0;
    end else if (shift_en) begin
      sh <= nxt;
      if (load_en) begin
        chan     <= nxt;
        chan_bad <= (int'(nxt) > MAX_CHAN);
      end
    end
  end
endmodule

// File: rtl/adcseq_strobe_gen.sv
module adcseq_strobe_gen #(
  parameter int CW        = 4,
  parameter int SAMPLE_AT = 6,
  parameter int HOLD_AT   = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_frame,
  input  logic [CW-1:0] rcnt,
  output logic          sample_pulse,
  output logic          hold_pulse
);
  logic [CW-1:0] prev;
  logic [1:0]    pulse;

  always_ff @(negedge clk) begin
    if (rst) prev <= '0;
    else     prev <= rcnt;
  end

  for (genvar g = 0; g < 2; g++) begin : g_strobe
    localparam int AT = (g == 0) ? SAMPLE_AT : HOLD_AT;
    always_ff @(negedge clk) begin
      if (rst) pulse[g] <= 1'b0;
      else     pulse[g] <= in_frame && (rcnt == CW'(AT)) && (prev != CW'(AT));
    end
  end

  assign sample_pulse = pulse[0];
  assign hold_pulse   = pulse[1];
endmodule

// File: rtl/adc_shared_clk_seq.sv
module adc_shared_clk_seq
  import adcseq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int RECOG_CYC   = 2,
  parameter int VALID_CYC   = 10,
  parameter int SAMPLE_CYC  = 4,
  parameter int MAX_CHAN    = 10,
  parameter int CONV_CYCLES = 44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              addr_in,
  output logic [ADDR_W-1:0] chan,
  output logic              chan_bad,
  output logic              sample_pulse,
  output logic              hold_pulse,
  output logic              conv_en,
  output logic              frame_err
);
  localparam int TOTAL = RECOG_CYC + VALID_CYC;
  localparam int CW    = $clog2(TOTAL + 1);

  phase_e        phase;
  logic [CW-1:0] rcnt;
  logic          shift_en;
  logic          load_en;

  adcseq_frame_ctl #(.TOTAL(TOTAL), .CONV_CYCLES(CONV_CYCLES)) u_ctl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .phase(phase), .rcnt(rcnt),
    .frame_err(frame_err), .conv_en(conv_en)
  );

  assign shift_en = (phase == PH_FRAME) && !cs_n &&
                    (rcnt >= CW'(RECOG_CYC)) && (rcnt < CW'(RECOG_CYC + ADDR_W));
  assign load_en  = shift_en && (rcnt == CW'(RECOG_CYC + ADDR_W - 1));

  adcseq_addr_shift #(.ADDR_W(ADDR_W), .MAX_CHAN(MAX_CHAN)) u_addr (
    .clk(clk), .rst(rst), .shift_en(shift_en), .load_en(load_en),
    .addr_in(addr_in), .chan(chan), .chan_bad(chan_bad)
  );

  adcseq_strobe_gen #(
    .CW(CW), .SAMPLE_AT(RECOG_CYC + SAMPLE_CYC), .HOLD_AT(TOTAL)
  ) u_strb (
    .clk(clk), .rst(rst), .in_frame(phase == PH_FRAME), .rcnt(rcnt),
    .sample_pulse(sample_pulse), .hold_pulse(hold_pulse)
  );
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sample_pulse,
  input logic hold_pulse,
  input logic conv_en,
  input logic frame_err
);
  assert_sample_one_clk_R5: assert property (@(negedge clk) disable iff (rst)
    sample_pulse |=> !sample_pulse);

  assert_hold_one_clk_R6: assert property (@(negedge clk) disable iff (rst)
    hold_pulse |=> !hold_pulse);

  assert_strobes_apart_R5: assert property (@(negedge clk) disable iff (rst)
    !(sample_pulse && hold_pulse));

  assert_err_needs_low_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_err) |-> !$past(cs_n));

  assert_conv_after_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_en) |-> $past(cs_n));

  assert_no_sample_in_conv_R9: assert property (@(posedge clk) disable iff (rst)
    conv_en |-> !sample_pulse);
endmodule

bind adc_shared_clk_seq adcseq_checker u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sample_pulse(sample_pulse),
  .hold_pulse(hold_pulse), .conv_en(conv_en), .frame_err(frame_err)
);

// File: tb/adc_shared_clk_seq_tb.sv
`timescale 1ns/1ps
module adc_shared_clk_seq_tb;
  localparam int CONV = 44;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       addr_in = 1'b0;
  logic [3:0] chan;
  logic       chan_bad, sample_pulse, hold_pulse, conv_en, frame_err;
  int n_cmp = 0;
  int n_bad = 0;

  adc_shared_clk_seq u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .addr_in(addr_in), .chan(chan),
    .chan_bad(chan_bad), .sample_pulse(sample_pulse), .hold_pulse(hold_pulse),
    .conv_en(conv_en), .frame_err(frame_err)
  );

  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Run one frame with cs_n low for nlow clocks, then raise it.
  task automatic frame(input logic [3:0] ch, input int nlow, input logic [3:0] old_ch);
    int cnt;
    for (int k = 1; k <= nlow; k++) begin
      cs_n    = 1'b0;
      addr_in = (k >= 3 && k <= 6) ? ch[6-k] : 1'b1;
      tick();
      check("R5 sample", sample_pulse, (k == 6) ? 1 : 0);
      check("R6 hold", hold_pulse, (k == 12) ? 1 : 0);
      check("R7 frame_err", frame_err, (k >= 13) ? 1 : 0);
      if (k == 6) begin
        check("R2/R3 chan", chan, ch);
        check("R4 chan_bad", chan_bad, (ch > 10) ? 1 : 0);
      end
    end
    cs_n = 1'b1;
    tick();
    check("R6 hold after rise", hold_pulse, 0);
    if (nlow < 12) begin
      check("R10 no conv", conv_en, 0);
      if (nlow < 6) check("R10 chan kept", chan, old_ch);
      for (int j = 0; j < 3; j++) begin
        tick();
        check("R10 conv stays off", conv_en, 0);
      end
      return;
    end
    check("R8 conv start", conv_en, 1);
    cnt = 1;
    for (int j = 0; j < 80 && conv_en; j++) begin
      cs_n = (j >= 3 && j < 9) ? 1'b0 : 1'b1;
      tick();
      if (conv_en) cnt++;
      if (sample_pulse || hold_pulse) check("R9 strobe in conv", 1, 0);
    end
    check("R8 conv length", cnt, CONV);
    for (int j = 0; j < 3; j++) begin
      tick();
      check("R9 idle after conv", sample_pulse | conv_en, 0);
    end
    check("R9 chan kept", chan, ch);
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] last;
    for (int i = 0; i < 3; i++) tick();
    check("R1 chan", chan, 0);
    check("R1 flags", {chan_bad, sample_pulse, hold_pulse, conv_en, frame_err}, 0);
    rst = 1'b0;
    tick();
    check("R1 idle", conv_en | sample_pulse, 0);
    last = 4'd0;
    for (int c = 0; c < 16; c++) begin
      frame(4'(c), 12, last);
      last = 4'(c);
    end
    frame(4'd9, 14, last);
    last = 4'd9;
    frame(4'd3, 12, last);
    last = 4'd3;
    frame(4'd12, 8, last);
    last = 4'd12;
    frame(4'd1, 4, last);
    frame(4'd10, 12, last);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule